// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block serialises characters onto an asynchronous line that idles high. It advances only on an enable tick that runs at sixteen times the baud rate, and each bit on the line lasts sixteen such ticks. A one-deep holding buffer sits in front of the shift register. Software can therefore hand over the next character while the current one is still leaving, and consecutive frames follow each other with no idle time between them.

Each frame is built from a set of control inputs. These choose 7, 8 or 9 data bits, optional hardware parity with one of four kinds, and one or two stop bits. In 9-bit frames, one shared control input supplies the ninth data bit. In 7-bit and 8-bit frames, the same input acts as the low half of the parity-kind selector. Characters enter through a valid/ready port. The `wr_ready` signal is high exactly while the holding buffer is empty. A write happens on a clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the producer must hold its character and keep `wr_valid` asserted until it is accepted. The block drops nothing and does not queue more than one character ahead.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After reset the line `txd` is high, `buf_empty` and `wr_ready` are 1, and `tx_busy` is 0.
- R2: While `tx_busy` is 0 the line is high. A frame starts with a low start bit, and data goes out least significant bit first. Every bit holds for TICKS_PER_BIT (16) enable ticks.
- R3: `len_sel` picks the data width: 2'b01 gives 7 bits, 2'b00 gives 8 bits, 2'b10 gives 9 bits, and 2'b11 is treated as 8 bits.
- R4: In 9-bit frames the ninth data bit, sent last, is `bit9_psel`, and no parity bit is sent whatever `par_en` says.
- R5: In 7-bit and 8-bit frames with `par_en`=1, one parity bit follows the data. Its kind is selected by {`psel_hi`,`bit9_psel`}: 00 odd (data plus parity has an odd count of ones), 01 even, 10 always 1, 11 always 0.
- R6: The frame ends with one high stop bit, or two when `two_stop`=1.
- R7: A write is accepted only when `wr_valid` and `wr_ready` are both 1, and `buf_empty` is 0 in the cycle after acceptance. A write offered while `wr_ready` is 0 changes neither `hold_data` nor anything sent on the line.
- R8: When the shift register is idle, or its final stop bit ends, and the buffer holds a character, that character moves into the shift register and `buf_empty` returns to 1. Back-to-back frames have no idle high time between the last stop bit and the next start bit.
- R9: `tx_busy` is 1 from the start bit of a frame until the end of the last stop bit of the last queued frame. It stays 1 across back-to-back frames.
- R10: `hold_data` shows the last accepted character and keeps it after the character moves to the shift register.
- R11: The frame settings (`len_sel`, `par_en`, `psel_hi`, `bit9_psel`, `two_stop`) are sampled when the character moves into the shift register. Later changes do not alter a frame already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at 16x the baud rate |
| wr_valid | input | 1 | Character offered |
| wr_ready | output | 1 | Holding buffer can take a character |
| wr_data | input | 8 | Character to send (low 8 data bits) |
| hold_data | output | 8 | Contents of the holding buffer |
| len_sel | input | 2 | Data-width code |
| par_en | input | 1 | Parity enable for 7/8-bit frames |
| psel_hi | input | 1 | High bit of the parity-kind selector |
| bit9_psel | input | 1 | Ninth data bit, or low parity-kind bit |
| two_stop | input | 1 | Send two stop bits |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding buffer is empty |
| tx_busy | output | 1 | A frame is on the line |

## Verification
The bench uses the default TICKS_PER_BIT of 16 and the default frame width of 12 positions. At that width the longest frames are reachable: nine data bits with two stop bits, and eight data bits with parity and two stop bits. It raises the enable tick on every second clock. This keeps each frame to a few hundred cycles, so every width code, every parity kind and both stop counts can be run in both directed and random sequences. That tick rate also makes the exact half-bit of stop time before a back-to-back start bit a countable quantity.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  localparam int CHAR_W    = 8;
  localparam int MAX_DATA  = CHAR_W + 1;
  localparam int FRAME_MAX = 1 + MAX_DATA + 2;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } par_kind_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       psel_hi;
    logic       bit9;
    logic       two_stop;
  } tx_cfg_t;

  function automatic int data_width(input logic [1:0] len);
    case (len)
      2'b01:   return 7;
      2'b10:   return 9;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         wr_ready,
  output logic         full,
  output logic [W-1:0] data
);
  logic         full_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (wr_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= wr_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign wr_ready = !full_q;
  assign full     = full_q;
  assign data     = data_q;
endmodule

// File: rtl/tx_frame_fmt.sv
module tx_frame_fmt
  import serial_tx_pkg::*;
#(
  parameter int FW   = FRAME_MAX,
  parameter int NB_W = $clog2(FW + 1)
) (
  input  logic [CHAR_W-1:0] data,
  input  tx_cfg_t           cfg,
  output logic [FW-1:0]     frame,
  output logic [NB_W-1:0]   nbits
);
  int                  dw;
  logic                nine;
  logic                use_par;
  logic                acc;
  logic                pbit;
  logic [MAX_DATA-1:0] d9;
  par_kind_e           kind;

  always_comb begin
    dw      = data_width(cfg.len);
    nine    = (dw == MAX_DATA);
    use_par = cfg.par_en && !nine;
    d9      = {cfg.bit9, data};
    kind    = par_kind_e'({cfg.psel_hi, cfg.bit9});
    acc     = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < dw) acc = acc ^ d9[i];
    end
    case (kind)
      PAR_ODD:  pbit = ~acc;
      PAR_EVEN: pbit = acc;
      PAR_MARK: pbit = 1'b1;
      default:  pbit = 1'b0;
    endcase

    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < dw) frame[1+i] = d9[i];
    end
    for (int j = 0; j < FW; j++) begin
      if (use_par && (j == 1 + dw)) frame[j] = pbit;
    end
    nbits = NB_W'(1 + dw + (use_par ? 1 : 0) + 1 + (cfg.two_stop ? 1 : 0));
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int TPB  = 16,
  parameter int FW   = 12,
  parameter int NB_W = $clog2(FW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            load,
  input  logic [FW-1:0]   frame,
  input  logic [NB_W-1:0] nbits,
  output logic            txd,
  output logic            busy,
  output logic            can_load
);
  localparam int TC_W = (TPB > 1) ? $clog2(TPB) : 1;

  logic [FW-1:0]   sh_q;
  logic [NB_W-1:0] remain_q;
  logic [TC_W-1:0] tcnt_q;
  logic            busy_q;
  logic            bit_end;
  logic            last_bit;

  assign bit_end  = (tcnt_q == TC_W'(TPB - 1));
  assign last_bit = (remain_q == NB_W'(1));
  assign can_load = !busy_q || (tick && bit_end && last_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '1;
      remain_q <= '0;
      tcnt_q   <= '0;
      busy_q   <= 1'b0;
    end else if (load) begin
      sh_q     <= frame;
      remain_q <= nbits;
      tcnt_q   <= '0;
      busy_q   <= 1'b1;
    end else if (busy_q && tick) begin
      if (bit_end) begin
        tcnt_q   <= '0;
        sh_q     <= {1'b1, sh_q[FW-1:1]};
        remain_q <= remain_q - NB_W'(1);
        if (last_bit) busy_q <= 1'b0;
      end else begin
        tcnt_q <= tcnt_q + TC_W'(1);
      end
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;
endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf
  import serial_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int FRAME_W       = FRAME_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CHAR_W-1:0] wr_data,
  output logic [CHAR_W-1:0] hold_data,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              psel_hi,
  input  logic              bit9_psel,
  input  logic              two_stop,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_busy
);
  localparam int NB_W = $clog2(FRAME_W + 1);

  logic               hold_full;
  logic               can_load;
  logic               take;
  tx_cfg_t            cfg;
  logic [FRAME_W-1:0] frame;
  logic [NB_W-1:0]    nbits;

  assign cfg  = '{len: len_sel, par_en: par_en, psel_hi: psel_hi,
                  bit9: bit9_psel, two_stop: two_stop};
  assign take = hold_full && can_load;

  tx_hold_buf #(.W(CHAR_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .take     (take),
    .wr_ready (wr_ready),
    .full     (hold_full),
    .data     (hold_data)
  );

  tx_frame_fmt #(.FW(FRAME_W), .NB_W(NB_W)) u_fmt (
    .data  (hold_data),
    .cfg   (cfg),
    .frame (frame),
    .nbits (nbits)
  );

  tx_shifter #(.TPB(TICKS_PER_BIT), .FW(FRAME_W), .NB_W(NB_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .load     (take),
    .frame    (frame),
    .nbits    (nbits),
    .txd      (txd),
    .busy     (tx_busy),
    .can_load (can_load)
  );

  assign buf_empty = !hold_full;
endmodule

// File: rtl/serial_tx_dbuf_chk.sv
module serial_tx_dbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] hold_data,
  input logic       txd,
  input logic       buf_empty,
  input logic       tx_busy
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R2
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd); // R2
  AST_WRITE_FILLS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !buf_empty); // R7
  AST_REFUSED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(hold_data)); // R7
  AST_TRANSFER_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> (tx_busy && !txd)); // R8
  AST_BUSY_ENDS_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(tick16 && txd)); // R9
endmodule

bind serial_tx_dbuf serial_tx_dbuf_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick16    (tick16),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .hold_data (hold_data),
  .txd       (txd),
  .buf_empty (buf_empty),
  .tx_busy   (tx_busy)
);

// File: tb/serial_tx_dbuf_tb.sv
module serial_tx_dbuf_tb;
  localparam int TPB  = 16;
  localparam int TDIV = 2;

  logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] len_sel = 2'b00;
  logic       par_en = 1'b0, psel_hi = 1'b0, bit9_psel = 1'b0, two_stop = 1'b0;
  wire        txd, wr_ready, buf_empty, tx_busy;
  wire  [7:0] hold_data;

  int n_cmp = 0, n_bad = 0;
  logic [11:0] q_vec[$];
  int          q_len[$];
  bit          q_b2b[$];
  string       q_tag[$];

  serial_tx_dbuf u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .hold_data(hold_data),
    .len_sel(len_sel), .par_en(par_en), .psel_hi(psel_hi),
    .bit9_psel(bit9_psel), .two_stop(two_stop), .txd(txd),
    .buf_empty(buf_empty), .tx_busy(tx_busy)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic void build(input logic [7:0] d, input logic [1:0] len,
                                input bit pen, input bit ph, input bit b9,
                                input bit ts, output logic [11:0] v, output int n);
    int dw;
    int pos;
    logic [8:0] dd;
    logic acc;
    logic p;
    dw = (len == 2'b01) ? 7 : ((len == 2'b10) ? 9 : 8);
    dd = {b9, d};
    v = '1;
    v[0] = 1'b0;
    acc = 1'b0;
    for (int i = 0; i < dw; i++) begin
      v[1+i] = dd[i];
      acc ^= dd[i];
    end
    pos = 1 + dw;
    if (pen && dw != 9) begin
      case ({ph, b9})
        2'b00: p = ~acc;
        2'b01: p = acc;
        2'b10: p = 1'b1;
        default: p = 1'b0;
      endcase
      v[pos] = p;
      pos++;
    end
    n = pos + 1 + (ts ? 1 : 0);
  endfunction

  // Enable tick, changed just after the rising edge
  initial begin
    int c = 0;
    forever begin
      @(posedge clk);
      #1;
      c = (c + 1) % TDIV;
      tick16 = (c == 0);
    end
  end

  // Line monitor: samples each bit at its centre
  initial begin
    bit inf = 0;
    int k = 0, bi = 0, gap = 0, el = 12;
    logic [11:0] got = '1, ev = '1;
    bit eb = 0;
    string tg = "R2";
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!inf) begin
          if (txd == 1'b0) begin
            if (q_len.size() == 0) begin
              check(0, "R2", "start bit with nothing queued", 0, 1);
              ev = '1; el = 12; eb = 0; tg = "R2";
            end else begin
              ev = q_vec.pop_front(); el = q_len.pop_front();
              eb = q_b2b.pop_front(); tg = q_tag.pop_front();
              if (eb) check(gap == TPB/2, "R8", "stop ticks before next start", gap, TPB/2);
            end
            inf = 1; k = 0; bi = 0; got = '1;
          end else if (tick16) begin
            gap++;
          end
        end
        if (inf && tick16) begin
          k++;
          if (k == TPB*bi + TPB/2) begin
            got[bi] = txd;
            check(tx_busy == 1'b1, "R9", "busy inside frame", tx_busy, 1);
            bi++;
            if (bi == el) begin
              check(got == ev, tg, "frame bits", got, ev);
              inf = 0; gap = 0;
            end
          end
        end
      end
    end
  end

  task automatic send(input logic [7:0] d, input logic [1:0] len, input bit pen,
                      input bit ph, input bit b9, input bit ts, input bit b2b,
                      input string tag);
    logic [11:0] v;
    int n;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    len_sel = len; par_en = pen; psel_hi = ph; bit9_psel = b9; two_stop = ts;
    wr_data = d; wr_valid = 1'b1;
    build(d, len, pen, ph, b9, ts, v, n);
    q_vec.push_back(v); q_len.push_back(n); q_b2b.push_back(b2b); q_tag.push_back(tag);
    @(negedge clk);
    wr_valid = 1'b0;
    check(hold_data == d, "R10", "holding buffer contents", hold_data, d);
    check(buf_empty == 1'b0, "R7", "buffer full after write", buf_empty, 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (q_len.size() != 0 || tx_busy) @(negedge clk);
    repeat (3 * TDIV * TPB) @(negedge clk);
    check(tx_busy == 1'b0, "R9", "busy low after last stop", tx_busy, 0);
    check(txd == 1'b1, "R2", "line idles high", txd, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] keep;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R1", "reset line", txd, 1);
    check(buf_empty == 1'b1, "R1", "reset empty", buf_empty, 1);
    check(wr_ready == 1'b1, "R1", "reset ready", wr_ready, 1);
    check(tx_busy == 1'b0, "R1", "reset busy", tx_busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send(8'hA5, 2'b00, 0, 0, 0, 0, 0, "R2");  wait_idle();
    send(8'hFF, 2'b01, 0, 0, 0, 0, 0, "R3");  wait_idle();
    send(8'h81, 2'b11, 0, 0, 0, 0, 0, "R3");  wait_idle();
    send(8'h3C, 2'b10, 1, 1, 1, 0, 0, "R4");  wait_idle();
    send(8'hC3, 2'b10, 1, 0, 0, 1, 0, "R4");  wait_idle();
    for (int kd = 0; kd < 4; kd++) begin
      send(8'h35, 2'b00, 1, kd[1], kd[0], 0, 0, "R5"); wait_idle();
      send(8'h4B, 2'b01, 1, kd[1], kd[0], 0, 0, "R5"); wait_idle();
    end
    send(8'h96, 2'b00, 0, 0, 0, 1, 0, "R6");  wait_idle();

    // Back-to-back frames with a refused write while full
    send(8'h11, 2'b00, 1, 0, 1, 1, 0, "R6");
    send(8'h22, 2'b01, 0, 0, 0, 0, 1, "R8");
    @(negedge clk);
    wr_data = 8'hE7; wr_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(wr_ready == 1'b0, "R7", "ready low while full", wr_ready, 0);
      check(hold_data == 8'h22, "R7", "refused write ignored", hold_data, 8'h22);
    end
    wr_valid = 1'b0;
    check(buf_empty == 1'b0, "R8", "no transfer before stop ends", buf_empty, 0);
    send(8'h5E, 2'b10, 0, 0, 1, 1, 1, "R8");
    keep = 8'h5E;
    @(negedge clk);
    while (!buf_empty) @(negedge clk);
    check(tx_busy == 1'b1, "R9", "busy across back-to-back", tx_busy, 1);
    check(hold_data == keep, "R10", "contents kept after transfer", hold_data, keep);
    wait_idle();

    // Settings change after transfer must not alter the frame
    send(8'h5A, 2'b00, 1, 0, 0, 0, 0, "R11");
    repeat (4) @(negedge clk);
    len_sel = 2'b01; par_en = 1'b0; psel_hi = 1'b1; bit9_psel = 1'b1; two_stop = 1'b1;
    wait_idle();

    // Random traffic
    for (int r = 0; r < 40; r++) begin
      logic [7:0] d;
      logic [1:0] ln;
      d  = 8'($urandom);
      ln = 2'($urandom);
      send(d, ln, bit'($urandom), bit'($urandom), bit'($urandom),
           bit'($urandom), 0, "R5");
      repeat ($urandom_range(0, 200)) @(negedge clk);
    end
    wait_idle();
    finish_run();
  end
endmodule